// File: doc/BRIEF.md
# Indirect masked table access controller

This block lets a narrow 16-bit host register port reach an internal table of 128 words, each 64 bits wide. The host never addresses the table directly. It stages a word in four 16-bit data lanes, loads four 16-bit protect lanes and a 7-bit word pointer, and then writes a control register. The control register holds a 5-bit target-memory code, a direction bit and a go bit. When the target code names this table, the go bit starts one transfer. A read copies the pointed-to word into the data lanes. A write merges the data lanes into the stored word, and every protect bit set to 1 keeps the stored bit as it was.

The table is a synchronous RAM with one cycle of read latency. A write is therefore carried out as a read, then a merge, then a write-back. Every transfer to this table takes three clock cycles from the go bit being set to the go bit clearing. While a transfer runs, the control register shows a busy flag, and host writes to any register are dropped. A go bit set with any other target code clears after one cycle and changes nothing.

Top module: `tbl_xfer_ctrl`

## Requirements
- R1: After reset, every host-visible register reads 0. This covers data lanes 0..3 at host addresses 0..3, protect lanes 0..3 at 4..7, the word pointer at 8 and the control register at 9.
- R2: A host write to an idle block stores the data, and the same address reads it back. Control register fields: bits 4..0 target code, bit 5 go, bit 6 direction (0 = read, 1 = write), bit 7 busy (read-only, always written as ignored). Bits 15..8 read 0.
- R3: A read transfer loads the 64-bit word into the data lanes, with lane 3 taking bits 63..48 and lane 0 taking bits 15..0. The protect lanes have no effect on a read.
- R4: A write transfer sets each stored bit to the data-lane bit where the matching protect bit is 0, and keeps the stored bit where the protect bit is 1.
- R5: The word pointer is 7 bits wide, and all 128 words can be addressed separately. Bits 15..7 of a pointer write are dropped and read back as 0.
- R6: With target code 1, the go bit and the busy flag read 1 for exactly three cycles after the clock edge that stores the go bit, and read 0 from then on.
- R7: With any target code other than 1, the go bit clears one cycle after it is stored, and neither the table nor the data lanes change.
- R8: While the go bit is set, host writes to the data lanes, the protect lanes, the pointer or the control register have no effect.
- R9: A write with all protect bits set to 1 leaves the word unchanged. A write with all protect bits set to 0 replaces the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address (0..9) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |

## Verification
The bench builds the block with its default parameters: 16-bit lanes, four lanes, 128 words and a 5-bit target code. With this size, every one of the 128 words can be loaded and then read back within a short run. Random masked writes are compared against a behavioural word array, alongside the all-ones and all-zeros protect cases. The busy flag is compared with a model on every cycle of each transfer. Writes are driven into the three busy cycles of a transfer, and each transfer is also run with a target code other than 1.

// File: rtl/tblx_pkg.sv
package tblx_pkg;

    // Transfer sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_FIN   = 2'd2
    } sq_state_e;

endpackage

// File: rtl/tblx_ram.sv
module tblx_ram #(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 128,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              re_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_q <= mem[addr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/tblx_seq.sv
module tblx_seq
    import tblx_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              hit_i,
    input  logic              dir_i,
    input  logic [AW-1:0]     war_i,
    input  logic [WORD_W-1:0] xfer_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic [WORD_W-1:0] ram_rdata_i,
    output logic [AW-1:0]     ram_addr_o,
    output logic              ram_re_o,
    output logic              ram_we_o,
    output logic [WORD_W-1:0] ram_wdata_o,
    output logic              load_o,
    output logic [WORD_W-1:0] load_data_o,
    output logic              done_o
);

    typedef struct packed {
        sq_state_e st;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        ram_re_o    = 1'b0;
        ram_we_o    = 1'b0;
        load_o      = 1'b0;
        done_o      = 1'b0;
        // protected bits keep the stored value, open bits take the lane data
        ram_wdata_o = (ram_rdata_i & mask_i) | (xfer_i & ~mask_i);
        load_data_o = ram_rdata_i;
        ram_addr_o  = war_i;
        case (s_q.st)
            SQ_IDLE: begin
                if (go_i) begin
                    if (hit_i) begin
                        ram_re_o = 1'b1;
                        s_d.st   = SQ_FETCH;
                    end else begin
                        done_o = 1'b1;
                    end
                end
            end
            SQ_FETCH: begin
                if (dir_i) begin
                    ram_we_o = 1'b1;
                end else begin
                    load_o = 1'b1;
                end
                s_d.st = SQ_FIN;
            end
            SQ_FIN: begin
                done_o = 1'b1;
                s_d.st = SQ_IDLE;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a finished table transfer only ever closes a running one
    p_fin_after_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_FIN) |-> ($past(s_q.st) == SQ_FETCH));

endmodule

// File: rtl/tblx_regs.sv
module tblx_regs #(
    parameter int LANE_W    = 16,
    parameter int LANES     = 4,
    parameter int AW        = 7,
    parameter int SEL_W     = 5,
    parameter int TABLE_SEL = 1,
    parameter int HA_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [HA_W-1:0]         addr_i,
    input  logic [LANE_W-1:0]       wdata_i,
    output logic [LANE_W-1:0]       rdata_o,
    input  logic                    load_i,
    input  logic [LANES*LANE_W-1:0] load_data_i,
    input  logic                    done_i,
    output logic [LANES*LANE_W-1:0] xfer_o,
    output logic [LANES*LANE_W-1:0] mask_o,
    output logic [AW-1:0]           war_o,
    output logic                    go_o,
    output logic                    hit_o,
    output logic                    dir_o
);

    localparam int START_B = SEL_W;
    localparam int DIR_B   = SEL_W + 1;
    localparam int BUSY_B  = SEL_W + 2;
    localparam int A_WAR   = 2 * LANES;
    localparam int A_CTRL  = 2 * LANES + 1;

    typedef struct packed {
        logic [LANES-1:0][LANE_W-1:0] xfer;
        logic [LANES-1:0][LANE_W-1:0] mask;
        logic [AW-1:0]                war;
        logic [SEL_W-1:0]             sel;
        logic                         start;
        logic                         dir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i && !r_q.start) begin
            for (int i = 0; i < LANES; i++) begin
                if (addr_i == HA_W'(i)) begin
                    r_d.xfer[i] = wdata_i;
                end
                if (addr_i == HA_W'(LANES + i)) begin
                    r_d.mask[i] = wdata_i;
                end
            end
            if (addr_i == HA_W'(A_WAR)) begin
                r_d.war = wdata_i[AW-1:0];
            end
            if (addr_i == HA_W'(A_CTRL)) begin
                r_d.sel   = wdata_i[SEL_W-1:0];
                r_d.start = wdata_i[START_B];
                r_d.dir   = wdata_i[DIR_B];
            end
        end
        if (load_i) begin
            r_d.xfer = load_data_i;
        end
        if (done_i) begin
            r_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (addr_i == HA_W'(i)) begin
                rdata_o = r_q.xfer[i];
            end
            if (addr_i == HA_W'(LANES + i)) begin
                rdata_o = r_q.mask[i];
            end
        end
        if (addr_i == HA_W'(A_WAR)) begin
            rdata_o[AW-1:0] = r_q.war;
        end
        if (addr_i == HA_W'(A_CTRL)) begin
            rdata_o[SEL_W-1:0] = r_q.sel;
            rdata_o[START_B]   = r_q.start;
            rdata_o[DIR_B]     = r_q.dir;
            rdata_o[BUSY_B]    = r_q.start;
        end
    end

    assign xfer_o = r_q.xfer;
    assign mask_o = r_q.mask;
    assign war_o  = r_q.war;
    assign go_o   = r_q.start;
    assign dir_o  = r_q.dir;
    assign hit_o  = (r_q.sel == SEL_W'(TABLE_SEL));

    // R7: a foreign target code releases the go bit on the next edge
    p_badsel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.start && !hit_o) |=> !r_q.start);

    // R3: lane loading only ever comes from a read transfer
    p_load_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (r_q.start && !r_q.dir));

    // R6: completion is only signalled while a transfer is pending
    p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> r_q.start);

    // R8: pointer and protect lanes hold while busy
    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r_q.start) |-> ($stable(r_q.war) && $stable(r_q.mask)));

    // R8: data lanes change during busy only by a read load
    p_xfer_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.start) && !$past(load_i)) |-> $stable(r_q.xfer));

endmodule

// File: rtl/tbl_xfer_ctrl.sv
module tbl_xfer_ctrl #(
    parameter int LANE_W    = 16,
    parameter int LANES     = 4,
    parameter int DEPTH     = 128,
    parameter int SEL_W     = 5,
    parameter int TABLE_SEL = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   host_we,
    input  logic [$clog2(2*LANES+2)-1:0]           host_addr,
    input  logic [LANE_W-1:0]                      host_wdata,
    output logic [LANE_W-1:0]                      host_rdata
);

    localparam int WORD_W = LANE_W * LANES;
    localparam int AW     = $clog2(DEPTH);
    localparam int HA_W   = $clog2(2 * LANES + 2);

    logic [WORD_W-1:0] xfer_w, mask_w, load_data_w;
    logic [WORD_W-1:0] ram_rdata_w, ram_wdata_w;
    logic [AW-1:0]     war_w, ram_addr_w;
    logic              go_w, hit_w, dir_w;
    logic              load_w, done_w, ram_re_w, ram_we_w;

    tblx_regs #(
        .LANE_W(LANE_W), .LANES(LANES), .AW(AW),
        .SEL_W(SEL_W), .TABLE_SEL(TABLE_SEL), .HA_W(HA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(host_we), .addr_i(host_addr), .wdata_i(host_wdata), .rdata_o(host_rdata),
        .load_i(load_w), .load_data_i(load_data_w), .done_i(done_w),
        .xfer_o(xfer_w), .mask_o(mask_w), .war_o(war_w),
        .go_o(go_w), .hit_o(hit_w), .dir_o(dir_w)
    );

    tblx_seq #(.WORD_W(WORD_W), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go_i(go_w), .hit_i(hit_w), .dir_i(dir_w), .war_i(war_w),
        .xfer_i(xfer_w), .mask_i(mask_w), .ram_rdata_i(ram_rdata_w),
        .ram_addr_o(ram_addr_w), .ram_re_o(ram_re_w), .ram_we_o(ram_we_w),
        .ram_wdata_o(ram_wdata_w), .load_o(load_w), .load_data_o(load_data_w),
        .done_o(done_w)
    );

    tblx_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk), .re_i(ram_re_w), .we_i(ram_we_w),
        .addr_i(ram_addr_w), .wdata_i(ram_wdata_w), .rdata_o(ram_rdata_w)
    );

    // R4: the table is only written inside a write transfer to this table
    p_we_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_w |-> (go_w && hit_w && dir_w));

    // R7: a foreign target code never reaches the table
    p_no_touch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_w && !hit_w) |-> (!ram_we_w && !ram_re_w));

endmodule

// File: tb/tb_tbl_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_tbl_xfer_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    always #2.5 clk = ~clk;

    tbl_xfer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] m_xfer [4];
    logic [15:0] m_mask [4];
    logic [6:0]  m_war;
    logic [4:0]  m_sel;
    logic        m_dir;
    logic [63:0] m_tbl [128];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input int a, input logic [15:0] exp, input string tag);
        host_addr = 4'(a);
        #1;
        chk(tag, host_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            rd_chk(i, m_xfer[i], tag);
            rd_chk(4 + i, m_mask[i], tag);
        end
        rd_chk(8, {9'b0, m_war}, tag);
        rd_chk(9, {8'b0, 1'b0, m_dir, 1'b0, m_sel}, tag);
    endtask

    task automatic hw(input int a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = 4'(a);
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (a < 4) m_xfer[a] = d;
        else if (a < 8) m_mask[a-4] = d;
        else if (a == 8) m_war = d[6:0];
        else begin
            m_sel = d[4:0];
            m_dir = d[6];
        end
    endtask

    task automatic model_xfer();
        logic [63:0] w, mw;
        w  = {m_xfer[3], m_xfer[2], m_xfer[1], m_xfer[0]};
        mw = {m_mask[3], m_mask[2], m_mask[1], m_mask[0]};
        if (m_sel == 5'd1) begin
            if (m_dir) m_tbl[m_war] = (m_tbl[m_war] & mw) | (w & ~mw);
            else for (int i = 0; i < 4; i++) m_xfer[i] = m_tbl[m_war][16*i +: 16];
        end
    endtask

    // start a transfer and compare the busy flag on every following cycle (R6, R7)
    task automatic run(input logic [4:0] sel, input logic dir);
        int n;
        n = (sel == 5'd1) ? 3 : 1;
        hw(9, {9'b0, dir, 1'b1, sel});
        for (int k = 0; k < n; k++) begin
            rd_chk(9, {8'b0, 1'b1, dir, 1'b1, sel}, (sel == 5'd1) ? "R6 busy" : "R7 busy");
            @(negedge clk);
        end
        model_xfer();
        rd_chk(9, {8'b0, 1'b0, dir, 1'b0, sel}, (sel == 5'd1) ? "R6 idle" : "R7 idle");
    endtask

    task automatic set_lanes(input logic [63:0] w, input logic [63:0] mw);
        for (int i = 0; i < 4; i++) begin
            hw(i, w[16*i +: 16]);
            hw(4 + i, mw[16*i +: 16]);
        end
    endtask

    task automatic read_word(input logic [6:0] a, input string tag);
        hw(8, {9'b0, a});
        run(5'd1, 1'b0);
        check_all(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] w, mw, old;
        for (int i = 0; i < 4; i++) begin
            m_xfer[i] = '0;
            m_mask[i] = '0;
        end
        m_war = '0; m_sel = '0; m_dir = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: register write and readback, busy bit and high bits dropped
        set_lanes(64'h1234_5678_9ABC_DEF0, 64'h0F0F_F0F0_AAAA_5555);
        hw(8, 16'h0055);
        hw(9, 16'hFF82);
        check_all("R2 readback");
        // R5: pointer upper bits dropped
        hw(8, 16'hFFFF);
        check_all("R5 pointer width");

        // R9 all-zero protect: fill every word (R5 distinct addressing)
        for (int a = 0; a < 128; a++) begin
            w = {16'(a * 7 + 3), 16'(a ^ 16'hA5A5), 16'(a << 5), 16'(~a)};
            if (a == 0) set_lanes(w, 64'h0);
            else for (int i = 0; i < 4; i++) hw(i, w[16*i +: 16]);
            hw(8, 16'(a));
            run(5'd1, 1'b1);
        end
        for (int a = 0; a < 128; a += 9) read_word(7'(a), "R5 R9 full write");
        read_word(7'd127, "R5 last word");

        // R3: protect lanes do not affect a read
        set_lanes(64'h0, 64'hFFFF_0000_FFFF_1234);
        read_word(7'd40, "R3 read ignores protect");

        // R9: all-ones protect keeps the word
        set_lanes(64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FFFF);
        hw(8, 16'd33);
        old = m_tbl[33];
        run(5'd1, 1'b1);
        read_word(7'd33, "R9 all-ones protect");
        chk("R9 word kept", m_tbl[33][15:0], old[15:0]);

        // R4: random masked writes then reads
        for (int t = 0; t < 80; t++) begin
            w  = {$urandom, $urandom};
            mw = {$urandom, $urandom};
            set_lanes(w, mw);
            hw(8, 16'($urandom_range(0, 127)));
            run(5'd1, 1'b1);
            read_word(7'($urandom_range(0, 127)), "R4 random masked write");
        end

        // R7: foreign target code, write and read directions
        set_lanes(64'h1111_2222_3333_4444, 64'h0);
        hw(8, 16'd10);
        run(5'd2, 1'b1);
        check_all("R7 lanes kept");
        run(5'd31, 1'b0);
        check_all("R7 no load");
        read_word(7'd10, "R7 table untouched");

        // R8: writes during busy are dropped
        set_lanes(64'h5A5A_A5A5_0F0F_F0F0, 64'h00FF_FF00_0000_FFFF);
        hw(8, 16'd77);
        hw(9, 16'h0061);
        host_we = 1'b1;
        host_addr = 4'd0; host_wdata = 16'hBEEF;
        @(negedge clk);
        host_addr = 4'd8; host_wdata = 16'd3;
        @(negedge clk);
        host_addr = 4'd9; host_wdata = 16'h0002;
        @(negedge clk);
        host_we = 1'b0;
        model_xfer();
        check_all("R8 writes ignored");
        read_word(7'd77, "R8 write hit old pointer");
        read_word(7'd3, "R8 other word kept");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule